// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel for a general-purpose timer. A counter outside the block supplies its current value, its count direction and an update-event pulse. The channel compares that count with its active compare value and produces the registered output-prepare level, which later stages use for polarity and pin drive. It also produces a compare-hit flag.

Software-style write strobes load the compare value and the channel configuration. The configuration holds a 3-bit mode, a buffering enable and an external-clear enable. With buffering on, a new compare value waits in a holding register until the next update event. A protection-level input can freeze the mode and the buffering enable while the channel is in compare use. An external clear input can pull the output low when it is enabled.

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset the output-prepare level is low, the mode is 3'b000, buffering and clear are disabled, and the active compare value is zero.
- R2: In mode 3'b000 the output-prepare level keeps its value, whatever the counter does.
- R3: On the clock edge where the counter equals the active compare value, mode 3'b001 sets the output high, mode 3'b010 sets it low and mode 3'b011 inverts it. In other cycles these modes hold the output.
- R4: Mode 3'b100 drives the output low and mode 3'b101 drives it high, on every cycle.
- R5: The PWM level is defined by the count direction (cnt_down=0 counts up, cnt_down=1 counts down). In mode 3'b110 while counting up, the level is high exactly when counter < compare. While counting down, it is low exactly when counter > compare.
- R6: Mode 3'b111 gives the inverse of the mode 3'b110 level in both count directions.
- R7: In a PWM mode the output takes the PWM level only in two cases: when the raw comparison result differs from its value in the previous cycle, or when the previous cycle was in mode 3'b000. Otherwise the output holds, for example just after leaving a forced mode.
- R8: When the clear enable is set and ext_clr is high at a clock edge, the output becomes low. This takes priority over every mode action.
- R9: With buffering enabled, a compare write only loads the holding register. The active value takes the held value at an update event.
- R10: With buffering disabled, a compare write loads the active value at the next edge. Update events then leave the active value unchanged.
- R11: A configuration write leaves the mode and the buffering enable unchanged when prot_lvl is 2'b11 and chan_cmp is high. The clear enable is still written.
- R12: cmp_hit is high in any cycle where the counter equals the active compare value, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 when the counter counts down |
| upd_evt | input | 1 | Update-event pulse from the counter |
| cv_wr | input | 1 | Compare-value write strobe |
| cv_wdata | input | CNT_W | Compare value to write |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Compare mode to write |
| cfg_shd_en | input | 1 | Buffering enable to write |
| cfg_clr_en | input | 1 | External-clear enable to write |
| prot_lvl | input | 2 | Protection level; 2'b11 is the lock level |
| chan_cmp | input | 1 | 1 when the channel is used for compare |
| ext_clr | input | 1 | External clear request |
| oprep | output | 1 | Output-prepare level |
| cmp_hit | output | 1 | Counter equals active compare value |

## Verification
The hardest situation to reach is the PWM hold rule of R7. The output has to sit at a level that disagrees with the PWM comparison while the comparison itself stays steady. The stimulus gets there by parking in a forced mode with the counter fixed, switching straight into a PWM mode, and then moving the counter across the compare value. The sweeps also enter each PWM mode from mode 3'b000 and run every compare value in both directions on a 4-bit counter. Each cycle is checked against an arithmetic model of the requirements.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

   typedef enum logic [2:0] {
      OC_FROZEN = 3'b000,
      OC_SET    = 3'b001,
      OC_CLR    = 3'b010,
      OC_TOG    = 3'b011,
      OC_LOW    = 3'b100,
      OC_HIGH   = 3'b101,
      OC_PWM_A  = 3'b110,
      OC_PWM_B  = 3'b111
   } oc_mode_e;

   localparam logic [1:0] PROT_LOCK = 2'b11;

   function automatic logic is_pwm(input oc_mode_e m);
      return (m == OC_PWM_A) || (m == OC_PWM_B);
   endfunction

endpackage

// File: rtl/tmr_cmp_cfg.sv
module tmr_cmp_cfg
   import tmr_cmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic [2:0] cfg_mode,
   input  logic       cfg_shd_en,
   input  logic       cfg_clr_en,
   input  logic [1:0] prot_lvl,
   input  logic       chan_cmp,
   output oc_mode_e   mode_q,
   output logic       shd_en_q,
   output logic       clr_en_q
);

   logic locked;

   // Mode and buffering enable freeze at the top protection level.
   assign locked = (prot_lvl == PROT_LOCK) && chan_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= OC_FROZEN;
         shd_en_q <= 1'b0;
         clr_en_q <= 1'b0;
      end else if (cfg_wr) begin
         clr_en_q <= cfg_clr_en;
         if (!locked) begin
            mode_q   <= oc_mode_e'(cfg_mode);
            shd_en_q <= cfg_shd_en;
         end
      end
   end

endmodule

// File: rtl/tmr_cmp_cvreg.sv
module tmr_cmp_cvreg #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shd_en,
   input  logic             cv_wr,
   input  logic [CNT_W-1:0] cv_wdata,
   input  logic             upd_evt,
   output logic [CNT_W-1:0] cv_act
);

   logic [CNT_W-1:0] cv_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cv_hold <= '0;
         cv_act  <= '0;
      end else begin
         if (cv_wr) cv_hold <= cv_wdata;
         if (cv_wr && !shd_en)     cv_act <= cv_wdata;
         else if (upd_evt && shd_en) cv_act <= cv_hold;
      end
   end

endmodule

// File: rtl/tmr_cmp_outgen.sv
module tmr_cmp_outgen
   import tmr_cmp_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_down,
   input  logic [CNT_W-1:0] cv_act,
   input  oc_mode_e         mode,
   input  logic             clr_act,
   output logic             hit,
   output logic             oprep_q,
   output oc_mode_e         mode_prev
);

   logic below, below_q, pwm_lvl, pwm_upd, op_nxt;

   assign hit     = (cnt_val == cv_act);
   // Raw comparison: high side of PWM mode A in the current direction.
   assign below   = cnt_down ? (cnt_val <= cv_act) : (cnt_val < cv_act);
   assign pwm_lvl = (mode == OC_PWM_A) ? below : ~below;
   assign pwm_upd = (below != below_q) || (mode_prev == OC_FROZEN);

   always_comb begin
      op_nxt = oprep_q;
      if (clr_act) begin
         op_nxt = 1'b0;
      end else begin
         unique case (mode)
            OC_FROZEN: op_nxt = oprep_q;
            OC_SET:    if (hit) op_nxt = 1'b1;
            OC_CLR:    if (hit) op_nxt = 1'b0;
            OC_TOG:    if (hit) op_nxt = ~oprep_q;
            OC_LOW:    op_nxt = 1'b0;
            OC_HIGH:   op_nxt = 1'b1;
            OC_PWM_A,
            OC_PWM_B:  if (pwm_upd) op_nxt = pwm_lvl;
            default:   op_nxt = oprep_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oprep_q   <= 1'b0;
         below_q   <= 1'b0;
         mode_prev <= OC_FROZEN;
      end else begin
         oprep_q   <= op_nxt;
         below_q   <= below;
         mode_prev <= mode;
      end
   end

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
   import tmr_cmp_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_down,
   input  logic             upd_evt,
   input  logic             cv_wr,
   input  logic [CNT_W-1:0] cv_wdata,
   input  logic             cfg_wr,
   input  logic [2:0]       cfg_mode,
   input  logic             cfg_shd_en,
   input  logic             cfg_clr_en,
   input  logic [1:0]       prot_lvl,
   input  logic             chan_cmp,
   input  logic             ext_clr,
   output logic             oprep,
   output logic             cmp_hit
);

   localparam int unsigned MIN_W = 2;
   localparam int unsigned MAX_W = 32;

   generate
      if (CNT_W < MIN_W || CNT_W > MAX_W) begin : g_bad_width
         $error("tmr_cmp_chan: CNT_W out of range");
      end
   endgenerate

   oc_mode_e         mode_q, mode_prev;
   logic             shd_en_q, clr_en_q, clr_act;
   logic [CNT_W-1:0] cv_act;

   assign clr_act = clr_en_q && ext_clr;

   tmr_cmp_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_mode   (cfg_mode),
      .cfg_shd_en (cfg_shd_en),
      .cfg_clr_en (cfg_clr_en),
      .prot_lvl   (prot_lvl),
      .chan_cmp   (chan_cmp),
      .mode_q     (mode_q),
      .shd_en_q   (shd_en_q),
      .clr_en_q   (clr_en_q)
   );

   tmr_cmp_cvreg #(.CNT_W(CNT_W)) u_cv (
      .clk      (clk),
      .rst_n    (rst_n),
      .shd_en   (shd_en_q),
      .cv_wr    (cv_wr),
      .cv_wdata (cv_wdata),
      .upd_evt  (upd_evt),
      .cv_act   (cv_act)
   );

   tmr_cmp_outgen #(.CNT_W(CNT_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_val   (cnt_val),
      .cnt_down  (cnt_down),
      .cv_act    (cv_act),
      .mode      (mode_q),
      .clr_act   (clr_act),
      .hit       (cmp_hit),
      .oprep_q   (oprep),
      .mode_prev (mode_prev)
   );

endmodule

// File: rtl/tmr_cmp_chan_chk.sv
module tmr_cmp_chan_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode_q,
   input logic [2:0]       mode_prev,
   input logic             shd_en_q,
   input logic             clr_en_q,
   input logic             ext_clr,
   input logic             cfg_wr,
   input logic [1:0]       prot_lvl,
   input logic             chan_cmp,
   input logic             cv_wr,
   input logic [CNT_W-1:0] cv_wdata,
   input logic             upd_evt,
   input logic [CNT_W-1:0] cv_act,
   input logic [CNT_W-1:0] cnt_val,
   input logic             cnt_down,
   input logic             cmp_hit,
   input logic             oprep
);

   logic clr_on;
   assign clr_on = clr_en_q && ext_clr;

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_on |=> !oprep);

   a_r4_force_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b101 && !clr_on) |=> oprep);

   a_r4_force_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b100) |=> !oprep);

   a_r2_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b000 && !clr_on) |=> $stable(oprep));

   a_r3_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b001 && cmp_hit && !clr_on) |=> oprep);

   a_r3_toggle_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b011 && cmp_hit && !clr_on) |=> (oprep != $past(oprep)));

   a_r5_pwm_entry_up: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_prev == 3'b000 && mode_q == 3'b110 && !clr_on && !cnt_down
       && cnt_val < cv_act) |=> oprep);

   a_r9_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (shd_en_q && !upd_evt) |=> $stable(cv_act));

   a_r10_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_wr && !shd_en_q) |=> (cv_act == $past(cv_wdata)));

   a_r11_lock_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && prot_lvl == 2'b11 && chan_cmp) |=> ($stable(mode_q) && $stable(shd_en_q)));

endmodule

bind tmr_cmp_chan tmr_cmp_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_q    (mode_q),
   .mode_prev (mode_prev),
   .shd_en_q  (shd_en_q),
   .clr_en_q  (clr_en_q),
   .ext_clr   (ext_clr),
   .cfg_wr    (cfg_wr),
   .prot_lvl  (prot_lvl),
   .chan_cmp  (chan_cmp),
   .cv_wr     (cv_wr),
   .cv_wdata  (cv_wdata),
   .upd_evt   (upd_evt),
   .cv_act    (cv_act),
   .cnt_val   (cnt_val),
   .cnt_down  (cnt_down),
   .cmp_hit   (cmp_hit),
   .oprep     (oprep)
);

// File: tb/test_tmr_cmp_chan.sv
module test_tmr_cmp_chan;

   localparam int W = 4;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] cnt_val = '0;
   logic cnt_down = 1'b0, upd_evt = 1'b0, cv_wr = 1'b0, cfg_wr = 1'b0;
   logic [W-1:0] cv_wdata = '0;
   logic [2:0] cfg_mode = 3'd0;
   logic cfg_shd_en = 1'b0, cfg_clr_en = 1'b0, chan_cmp = 1'b0, ext_clr = 1'b0;
   logic [1:0] prot_lvl = 2'b00;
   logic oprep, cmp_hit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference state computed from the requirements.
   logic       e_op = 1'b0, e_shen = 1'b0, e_clren = 1'b0, e_below = 1'b0;
   logic [2:0] e_mode = 3'd0, e_pmode = 3'd0;
   logic [W-1:0] e_cv = '0, e_hold = '0;

   always #2 clk = ~clk;

   tmr_cmp_chan #(.CNT_W(W)) i_tmr_cmp_chan (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
      .upd_evt(upd_evt), .cv_wr(cv_wr), .cv_wdata(cv_wdata), .cfg_wr(cfg_wr),
      .cfg_mode(cfg_mode), .cfg_shd_en(cfg_shd_en), .cfg_clr_en(cfg_clr_en),
      .prot_lvl(prot_lvl), .chan_cmp(chan_cmp), .ext_clr(ext_clr),
      .oprep(oprep), .cmp_hit(cmp_hit)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // One clock: check the hit flag, advance the model, then check the output.
   task automatic step(input string tag);
      logic below, hit, clr, nop, lock;
      #1;
      hit   = (cnt_val == e_cv);
      chk(tag, cmp_hit, hit);
      below = cnt_down ? (cnt_val <= e_cv) : (cnt_val < e_cv);
      clr   = e_clren && ext_clr;
      nop   = e_op;
      if (clr) nop = 1'b0;
      else case (e_mode)
         3'd1: if (hit) nop = 1'b1;
         3'd2: if (hit) nop = 1'b0;
         3'd3: if (hit) nop = ~e_op;
         3'd4: nop = 1'b0;
         3'd5: nop = 1'b1;
         3'd6, 3'd7:
            if (below != e_below || e_pmode == 3'd0)
               nop = (e_mode == 3'd6) ? below : ~below;
         default: nop = e_op;
      endcase
      @(posedge clk);
      e_op    = nop;
      e_below = below;
      e_pmode = e_mode;
      if (cv_wr && !e_shen) e_cv = cv_wdata;
      else if (upd_evt && e_shen) e_cv = e_hold;
      if (cv_wr) e_hold = cv_wdata;
      lock = (prot_lvl == 2'b11) && chan_cmp;
      if (cfg_wr) begin
         e_clren = cfg_clr_en;
         if (!lock) begin
            e_mode = cfg_mode;
            e_shen = cfg_shd_en;
         end
      end
      #1;
      cv_wr = 1'b0; cfg_wr = 1'b0; upd_evt = 1'b0;
      chk(tag, oprep, e_op);
   endtask

   task automatic set_cfg(input logic [2:0] m, input logic sh, input logic ce, input string tag);
      cfg_mode = m; cfg_shd_en = sh; cfg_clr_en = ce; cfg_wr = 1'b1;
      step(tag);
   endtask

   task automatic write_cv(input logic [W-1:0] v, input string tag);
      cv_wdata = v; cv_wr = 1'b1;
      step(tag);
   endtask

   task automatic sweep(input logic down, input string tag);
      cnt_down = down;
      for (int k = 0; k <= MAXV; k++) begin
         cnt_val = down ? W'(MAXV - k) : W'(k);
         step(tag);
      end
   endtask

   initial begin
      #((200000) * 4);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state, compare value zero seen through cmp_hit
      chk("R1", oprep, 1'b0);
      cnt_val = 0; #1 chk("R1", cmp_hit, 1'b1);
      cnt_val = 3; #1 chk("R1", cmp_hit, 1'b0);
      step("R1");

      // R4: forced levels
      set_cfg(3'd5, 0, 0, "R4"); step("R4"); chk("R4", oprep, 1'b1);
      set_cfg(3'd4, 0, 0, "R4"); step("R4"); chk("R4", oprep, 1'b0);

      // R2: frozen mode holds a high level across matches
      set_cfg(3'd5, 0, 0, "R2");
      set_cfg(3'd0, 0, 0, "R2");
      write_cv(4'd6, "R2");
      sweep(0, "R2"); chk("R2", oprep, 1'b1);

      // R3 / R10: match-driven modes with direct compare writes
      for (int m = 1; m <= 3; m++) begin
         set_cfg(3'(m), 0, 0, "R3");
         write_cv(4'd7, "R10");
         cnt_val = 7; #1 chk("R10", cmp_hit, 1'b1);
         sweep(0, "R3");
         sweep(1, "R3");
      end

      // R5 / R6: PWM sweeps, entered from frozen mode
      for (int m = 6; m <= 7; m++)
         for (int d = 0; d <= 1; d++)
            for (int v = 0; v <= MAXV; v++) begin
               set_cfg(3'd0, 0, 0, (m == 6) ? "R5" : "R6");
               write_cv(4'(v), "R10");
               cnt_down = d[0];
               cnt_val  = d[0] ? 4'(MAXV) : 4'd0;
               set_cfg(3'(m), 0, 0, (m == 6) ? "R5" : "R6");
               sweep(d[0], (m == 6) ? "R5" : "R6");
               sweep(d[0], (m == 6) ? "R5" : "R6");
            end

      // R7: leave forced-high into PWM while comparison says low: holds
      write_cv(4'd5, "R7");
      cnt_down = 0; cnt_val = 4'd9;
      set_cfg(3'd5, 0, 0, "R7");
      step("R7");
      set_cfg(3'd6, 0, 0, "R7");
      step("R7"); step("R7"); chk("R7", oprep, 1'b1);
      cnt_val = 4'd2; step("R7"); step("R7"); chk("R7", oprep, 1'b1);
      cnt_val = 4'd8; step("R7"); chk("R7", oprep, 1'b0);

      // R8: clear enable with external clear
      set_cfg(3'd5, 0, 1, "R8"); step("R8");
      ext_clr = 1'b1; step("R8"); chk("R8", oprep, 1'b0);
      ext_clr = 1'b0; step("R8"); chk("R8", oprep, 1'b1);
      set_cfg(3'd5, 0, 0, "R8");
      ext_clr = 1'b1; step("R8"); chk("R8", oprep, 1'b1);
      ext_clr = 1'b0;

      // R9: buffered compare writes
      set_cfg(3'd0, 1, 0, "R9");
      write_cv(4'd9, "R9");
      cnt_val = 4'd9; #1 chk("R9", cmp_hit, 1'b0);
      step("R9"); step("R9");
      upd_evt = 1'b1; step("R9");
      #1 chk("R9", cmp_hit, 1'b1);
      step("R9");

      // R11: lock keeps mode and buffering
      set_cfg(3'd5, 0, 0, "R11");
      prot_lvl = 2'b11; chan_cmp = 1'b1;
      set_cfg(3'd4, 1, 0, "R11"); step("R11"); chk("R11", oprep, 1'b1);
      write_cv(4'd3, "R11");
      cnt_val = 4'd3; #1 chk("R11", cmp_hit, 1'b1);
      chan_cmp = 1'b0;
      set_cfg(3'd4, 0, 0, "R11"); step("R11"); chk("R11", oprep, 1'b0);
      prot_lvl = 2'b10; chan_cmp = 1'b1;
      set_cfg(3'd5, 0, 0, "R11"); step("R11"); chk("R11", oprep, 1'b1);
      prot_lvl = 2'b00; chan_cmp = 1'b0;

      // R12: hit flag in a forced mode and in frozen mode
      set_cfg(3'd4, 0, 0, "R12");
      write_cv(4'd11, "R12");
      for (int k = 0; k <= MAXV; k++) begin cnt_val = 4'(k); step("R12"); end
      set_cfg(3'd0, 0, 0, "R12");
      cnt_val = 4'd11; #1 chk("R12", cmp_hit, 1'b1);
      step("R12");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule